// File: doc/BRIEF.md
# Phased Backplane Bus Slave

This block is the register-access slave of a board sitting on a synchronous backplane. The backplane period is split into seven phases of a faster master clock. A marker input flags phase 0, the cycle that carries a serial start bit. The slave tracks the phase and takes a snapshot of strobe, write flag, address and data at one fixed phase. It turns that snapshot into a one-cycle write or read strobe on a plain register-file port.

Read results are not returned in the same period. They go back to the master in a fixed window of the following period. The data and acknowledge lines are enabled only inside that window. This leaves the master several idle phases in which it can take the shared data lines back.

Top module: `bp_slave`

## Requirements
- R1: Phases are counted from the last `start_i` pulse, which marks phase 0, and advance by one per master clock. Until the first `start_i` pulse after reset, no access is recognised, whatever the bus inputs do.
- R2: Strobe, write flag, address and data are taken only from the cycle at phase 4. Their values in any other phase have no effect on `rf_addr_o`, `rf_wdata_o` or the strobes.
- R3: If `as_i` is low at phase 4, the period produces no register-file strobe and no read response in the next period.
- R4: A write (`as_i`=1, `we_i`=1 at phase 4) raises `rf_we_o` for exactly one cycle, in phase 5, with the sampled address and data on `rf_addr_o`/`rf_wdata_o`. A write produces no acknowledge. `rf_we_o` and `rf_re_o` are never high together.
- R5: A read (`as_i`=1, `we_i`=0 at phase 4) raises `rf_re_o` for exactly one cycle, in phase 5, with the sampled address on `rf_addr_o`. `rf_rdata_i` is taken in that same cycle.
- R6: A read's response appears in the next bus period. `data_oe_o`, `ack_oe_o` and `ack_o` are high in phases 3, 4, 5 and 6 of that period.
- R7: During the response, `data_o` is all zeros in phase 3 and holds the captured read data in phases 4 to 6.
- R8: Outside a response window, `data_oe_o`, `ack_oe_o`, `ack_o` and `data_o` are all zero (lines released). This leaves phases 0 to 2 of every period free for turnaround.
- R9: Reads in consecutive periods each return their own data. A new read taken while an earlier response is being driven does not disturb that response.
- R10: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, seven cycles per bus period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | High in the phase-0 cycle of each bus period |
| as_i | input | 1 | Address strobe from the bus, active high |
| we_i | input | 1 | Bus write flag (1 write, 0 read) |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus data driven by the master |
| data_o | output | DATA_W | Data toward the bus pads |
| data_oe_o | output | 1 | Output enable of the data pads |
| ack_o | output | 1 | Acknowledge toward the bus pad |
| ack_oe_o | output | 1 | Output enable of the acknowledge pad |
| rf_addr_o | output | ADDR_W | Register-file address |
| rf_wdata_o | output | DATA_W | Register-file write data |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_re_o | output | 1 | Register-file read strobe |
| rf_rdata_i | input | DATA_W | Register-file read data, combinational on `rf_addr_o` |

## Verification
A phase counter that has slipped moves the strobe and the pad enables together, so the mismatch shows within one bus period. It appears as `rf_we_o`/`rf_re_o` outside phase 5 or `data_oe_o` outside phases 3 to 6. A lost or doubled pending-read flag gives a missing or extra four-cycle acknowledge burst in the period after the access. A single shared data stage, where two are needed, shows up in phase 6 of back-to-back reads. In that case the driven word changes to the newer read's data.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int unsigned PHASES = 7;
  localparam int unsigned PH_W   = $clog2(PHASES);
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_START  = phase_t'(0);
  localparam phase_t PH_DRIVE  = phase_t'(3);
  localparam phase_t PH_VALID  = phase_t'(4);
  localparam phase_t PH_SAMPLE = phase_t'(4);
  localparam phase_t PH_LAST   = phase_t'(PHASES - 1);
endpackage

// File: rtl/bps_phase.sv
module bps_phase
  import bps_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_t phase_o,
  output logic   locked_o
);
  phase_t ph_q;
  logic   lock_q;

  // start marker overrides the running count in its own cycle
  assign phase_o  = start_i ? PH_START : ph_q;
  assign locked_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_START;
      lock_q <= 1'b0;
    end else begin
      ph_q <= (phase_o == PH_LAST) ? PH_START : phase_o + phase_t'(1);
      if (start_i) lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bps_capture.sv
module bps_capture
  import bps_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_t            phase_i,
  input  logic              locked_i,
  input  logic              as_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_stb_o,
  output logic              rd_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              take;
  logic              wr_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign take = locked_i && (phase_i == PH_SAMPLE) && as_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      wr_q <= take &&  we_i;
      rd_q <= take && !we_i;
      if (take) begin
        addr_q  <= addr_i;
        wdata_q <= data_i;
      end
    end
  end

  assign wr_stb_o = wr_q;
  assign rd_stb_o = rd_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
endmodule

// File: rtl/bps_drive.sv
module bps_drive
  import bps_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_t            phase_i,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_o,
  output logic              ack_oe_o
);
  logic              pend_q, act_q;
  logic [DATA_W-1:0] pend_dat_q, act_dat_q;
  logic              in_win, drv;

  // two stages: a read taken in phase 5 must not disturb the word in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_dat_q <= '0;
      act_q      <= 1'b0;
      act_dat_q  <= '0;
    end else begin
      if (rd_stb_i) begin
        pend_q     <= 1'b1;
        pend_dat_q <= rdata_i;
      end else if (phase_i == PH_START) begin
        pend_q <= 1'b0;
      end
      if (phase_i == PH_START) begin
        act_q     <= pend_q;
        act_dat_q <= pend_dat_q;
      end
    end
  end

  assign in_win    = (phase_i >= PH_DRIVE) && (phase_i <= PH_LAST);
  assign drv       = act_q && in_win;
  assign data_oe_o = drv;
  assign ack_oe_o  = drv;
  assign ack_o     = drv;
  assign data_o    = (drv && phase_i >= PH_VALID) ? act_dat_q : '0;
endmodule

// File: rtl/bp_slave.sv
module bp_slave
  import bps_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              as_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_o,
  output logic              ack_oe_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              rf_we_o,
  output logic              rf_re_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  phase_t phase;
  logic   locked;
  logic   rd_stb;

  bps_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .phase_o  (phase),
    .locked_o (locked)
  );

  bps_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_i  (phase),
    .locked_i (locked),
    .as_i     (as_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .wr_stb_o (rf_we_o),
    .rd_stb_o (rd_stb),
    .addr_o   (rf_addr_o),
    .wdata_o  (rf_wdata_o)
  );

  assign rf_re_o = rd_stb;

  bps_drive #(.DATA_W(DATA_W)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .rd_stb_i  (rd_stb),
    .rdata_i   (rf_rdata_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ack_o     (ack_o),
    .ack_oe_o  (ack_oe_o)
  );
endmodule

// File: rtl/bp_slave_chk.sv
module bp_slave_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              as_i,
  input logic              we_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              ack_o,
  input logic              ack_oe_o,
  input logic              rf_we_o,
  input logic              rf_re_o
);
  logic [2:0] ck_q;
  logic [2:0] ck_cur;
  logic       ck_lock;

  assign ck_cur = start_i ? 3'd0 : ck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q    <= 3'd0;
      ck_lock <= 1'b0;
    end else begin
      ck_q <= (ck_cur == 3'd6) ? 3'd0 : ck_cur + 3'd1;
      if (start_i) ck_lock <= 1'b1;
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && rf_re_o)); // R4
  AST_WR_FROM_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(ck_lock && ck_cur == 3'd4 && as_i && we_i)); // R4
  AST_RD_FROM_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_re_o |-> $past(ck_lock && ck_cur == 3'd4 && as_i && !we_i)); // R5
  AST_IDLE_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_cur == 3'd4 && !as_i) |=> !(rf_we_o || rf_re_o)); // R3
  AST_PRELOCK_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ck_lock && !start_i) |=> !(rf_we_o || rf_re_o)); // R1
  AST_WIN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> ck_cur == 3'd3); // R6
  AST_ACK_TRACKS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_oe_o == data_oe_o) && (ack_o == data_oe_o)); // R6
  AST_PH3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && ck_cur == 3'd3) |-> data_o == '0); // R7
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && ck_cur > 3'd4) |-> $stable(data_o)); // R7
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_cur < 3'd3) |-> !data_oe_o); // R8
  AST_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0 && !ack_o)); // R8
endmodule

bind bp_slave bp_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .as_i      (as_i),
  .we_i      (we_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .ack_o     (ack_o),
  .ack_oe_o  (ack_oe_o),
  .rf_we_o   (rf_we_o),
  .rf_re_o   (rf_re_o)
);

// File: tb/tb_bp_slave.sv
`timescale 1ns/1ps
module tb_bp_slave;
  localparam int AW = 9;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, as, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdat;
  logic [DW-1:0] data_o, rf_wdata, rf_rdata;
  logic [AW-1:0] rf_addr;
  logic data_oe, ack, ack_oe, rf_we, rf_re;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return {a[7:0], ~a[7:0]} ^ {7'h2d, a};
  endfunction
  assign rf_rdata = mem_f(rf_addr);

  bp_slave #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .as_i(as), .we_i(we),
    .addr_i(addr), .data_i(wdat), .data_o(data_o), .data_oe_o(data_oe),
    .ack_o(ack), .ack_oe_o(ack_oe), .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata),
    .rf_we_o(rf_we), .rf_re_o(rf_re), .rf_rdata_i(rf_rdata)
  );

  int n_chk = 0, n_fail = 0, n_stb = 0, n_oe = 0;
  bit cmp_en = 0, finished = 0;
  string data_tag = "R7";

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: phase, bus period index, queue of pending responses
  int m_ph = -1, m_b = 0;
  logic m_we = 0, m_re = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0;
  int q_cyc[$];
  logic [DW-1:0] q_dat[$];
  int pc, pb, nc, nb;
  bit drv;

  always @(posedge clk) begin
    if (rf_we || rf_re) n_stb++;
    if (data_oe) n_oe++;
    if (rst_n) begin
      pc = start ? 0 : m_ph;
      pb = start ? m_b + 1 : m_b;
      if (q_cyc.size() > 0 && q_cyc[0] == pb - 1 && pc == 6) begin
        void'(q_cyc.pop_front());
        void'(q_dat.pop_front());
      end
      m_we = (pc == 4) && as && we;
      m_re = (pc == 4) && as && !we;
      if (pc == 4 && as) begin
        m_addr = addr;
        m_wd = wdat;
      end
      if (m_re) begin
        q_cyc.push_back(pb);
        q_dat.push_back(mem_f(addr));
      end
      m_ph = (pc < 0) ? -1 : (pc == 6 ? 0 : pc + 1);
      m_b = pb;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      nc = start ? 0 : m_ph;
      nb = start ? m_b + 1 : m_b;
      drv = q_cyc.size() > 0 && q_cyc[0] == nb - 1 && nc >= 3 && nc <= 6;
      chk(drv ? "R6" : "R8", "data_oe", data_oe, drv);
      chk(drv ? "R6" : "R8", "ack_oe", ack_oe, drv);
      chk(drv ? "R6" : "R8", "ack", ack, drv);
      chk(drv ? data_tag : "R8", "data", data_o, (drv && nc >= 4) ? q_dat[0] : '0);
      chk("R4", "rf_we", rf_we, m_we);
      chk("R5", "rf_re", rf_re, m_re);
      if (m_we || m_re) chk("R2", "rf_addr", rf_addr, m_addr);
      if (m_we) chk("R2", "rf_wdata", rf_wdata, m_wd);
    end
  end

  // one bus period; true values only in phases 3..5, inverted elsewhere
  task automatic bus_cycle(input logic a, input logic w, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    for (int p = 0; p < 7; p++) begin
      @(posedge clk); #1;
      start = (p == 0);
      if (p >= 3 && p <= 5) begin
        as = a; we = w; addr = ad; wdat = d;
      end else begin
        as = ~a; we = ~w; addr = ~ad; wdat = ~d;
      end
    end
  endtask

  int s0, o0;

  initial begin
    start = 0; as = 0; we = 0; addr = '0; wdat = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R10", "reset outputs", {data_o, data_oe, ack, ack_oe, rf_we, rf_re}, '0);
    end
    @(posedge clk); #1;
    rst_n = 1; cmp_en = 1;

    // R1: heavy bus activity before any start marker
    s0 = n_stb;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      as = 1; we = i[0]; addr = AW'(i * 37); wdat = DW'(i * 911);
    end
    chk("R1", "strobes before lock", n_stb - s0, 0);

    // R4: single write
    s0 = n_stb;
    bus_cycle(1, 1, 9'h0a5, 16'hbeef);
    chk("R4", "write strobe count", n_stb - s0, 1);

    // R6: read then two idle periods
    o0 = n_oe;
    bus_cycle(1, 0, 9'h0a5, 16'h0);
    bus_cycle(0, 0, 9'h000, 16'h0);
    bus_cycle(0, 0, 9'h000, 16'h0);
    chk("R6", "response cycles", n_oe - o0, 4);

    // R3: strobe low at sample point, active elsewhere
    s0 = n_stb; o0 = n_oe;
    bus_cycle(0, 0, 9'h1f0, 16'h1234);
    bus_cycle(0, 1, 9'h033, 16'h5678);
    bus_cycle(0, 0, 9'h000, 16'h0);
    chk("R3", "strobes when idle", n_stb - s0, 0);
    chk("R3", "drive when idle", n_oe - o0, 0);

    // R9: back-to-back reads
    data_tag = "R9";
    o0 = n_oe;
    for (int i = 0; i < 4; i++) bus_cycle(1, 0, AW'(9'h100 + i * 5), 16'h0);
    bus_cycle(0, 0, 9'h000, 16'h0);
    bus_cycle(0, 0, 9'h000, 16'h0);
    chk("R9", "back-to-back response cycles", n_oe - o0, 16);
    data_tag = "R7";

    // mixed random traffic
    for (int i = 0; i < 40; i++)
      bus_cycle(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom));
    bus_cycle(0, 0, 9'h000, 16'h0);
    bus_cycle(0, 0, 9'h000, 16'h0);
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule